// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This controller decides which of four operating modes a combined bus transceiver and voltage regulator chip is in, and drives the enables that follow from that mode. The four modes are fail-safe, normal, silent and sleep. It watches five things: the enable pin, the transmit pin, a reset request from the undervoltage and watchdog logic, an active-low local wake pin and an ignition pin. All pins are synchronised inside the block. Both wake inputs pass through their own debounce filters, and the two filters have different lengths.

After reset, or whenever the reset request is high, the chip sits in fail-safe mode. In that mode the regulator and the inhibit switch are on and the bus transceiver is off. Raising enable moves the chip to normal mode, where everything is on. Dropping enable leads to one of two low-power modes, chosen by the transmit pin. A high transmit pin selects silent mode, in which only the regulator stays on. A low transmit pin selects sleep mode, in which everything is off.

The transmit pin may fall a short, configurable time after enable and the request still counts as sleep. Once the chip is in a low-power mode, only a debounced wake event brings it back, and it always returns to fail-safe. While in fail-safe, the block reports which source caused entry so the pads can signal it.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_o` = 2'b00 (fail-safe). The regulator, inhibit and watchdog enables are 1, the transceiver enable is 0, and `wake_src_o` = 2'b11 (power-up/reset).
- R2: In fail-safe mode, `en_i` high moves the block to normal mode (`mode_o` = 2'b01), where all four enables are 1. Normal mode can be entered only from fail-safe.
- R3: In normal mode, if `en_i` falls while `txd_i` is high, the block enters silent mode (`mode_o` = 2'b10). In silent mode only the regulator enable is 1.
- R4: In normal mode, if `en_i` falls while `txd_i` is low, the block enters sleep mode (`mode_o` = 2'b11). In sleep mode all four enables are 0.
- R5: If `txd_i` falls up to `SKEW_CYC` cycles after `en_i` falls out of normal mode, and `en_i` is still low, the block goes from silent to sleep. If `txd_i` falls one cycle later than that, the block stays in silent mode.
- R6: In silent or sleep mode, `wake_n_i` held low for at least `LWAKE_DEB_CYC` cycles returns the block to fail-safe with `wake_src_o` = 2'b01. A shorter low pulse has no effect.
- R7: In silent or sleep mode, a rising `ign_i` that stays high for at least `IGN_DEB_CYC` cycles returns the block to fail-safe with `wake_src_o` = 2'b10. A shorter pulse, an input that simply stays high, and a falling edge all cause no wake.
- R8: When both wake filters fire in the same cycle, the local wake wins and `wake_src_o` = 2'b01.
- R9: In silent and sleep mode, changes on `en_i` and `txd_i` have no effect, apart from the transition described in R5.
- R10: `sbc_reset_i` high forces fail-safe with `wake_src_o` = 2'b11 on the next edge, from any mode. It overrides a high `en_i`.
- R11: Debounced wake events in fail-safe or normal mode do not change the mode.
- R12: `wake_src_o` is 2'b00 in every mode other than fail-safe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbc_reset_i | input | 1 | Reset request from undervoltage or watchdog logic, active high, synchronous |
| en_i | input | 1 | Enable pin (asynchronous) |
| txd_i | input | 1 | Transmit pin level (asynchronous) |
| wake_n_i | input | 1 | Local wake pin, active low (asynchronous) |
| ign_i | input | 1 | Ignition pin, wakes on a rising edge (asynchronous) |
| mode_o | output | 2 | Mode code: 00 fail-safe, 01 normal, 10 silent, 11 sleep |
| reg_on_o | output | 1 | Regulator enable |
| inh_on_o | output | 1 | Inhibit high-side switch enable |
| xcvr_en_o | output | 1 | Bus transceiver enable |
| wdog_en_o | output | 1 | Watchdog enable |
| wake_src_o | output | 2 | Fail-safe entry cause: 01 local, 10 ignition, 11 power-up/reset, 00 outside fail-safe |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the two wake filters: the ignition pulse is started `IGN_DEB_CYC - LWAKE_DEB_CYC` cycles before the local wake pulse, so both filters complete on one edge, and the reported source must be local. The second pair is the skew window closing and the transmit pin falling: the bench drops transmit exactly `SKEW_CYC` cycles after enable, and then one cycle later. The resulting mode shows on which side of the window boundary each case fell.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
  typedef enum logic [1:0] {
    MODE_FAILSAFE = 2'b00,
    MODE_NORMAL   = 2'b01,
    MODE_SILENT   = 2'b10,
    MODE_SLEEP    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_LOCAL = 2'b01,
    SRC_IGN   = 2'b10,
    SRC_POWER = 2'b11
  } src_e;
endpackage

// File: rtl/xmc_sync.sv
module xmc_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xmc_debounce.sv
// Level filter: the filtered state follows the input only after the input
// has differed from it for DEB_CYC consecutive cycles. rise_o pulses for
// one cycle when the filtered state turns active.
module xmc_debounce #(
  parameter int DEB_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic rise_o
);
  localparam int CW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_comb begin
    cnt_d  = cnt_q;
    filt_d = filt_q;
    rise_o = 1'b0;
    if (act_i == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      filt_d = act_i;
      rise_o = act_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end
endmodule

// File: rtl/xmc_skew_window.sv
// Opens a window of SKEW_CYC cycles after arm_i, during which a late
// transmit-low still counts as a sleep request.
module xmc_skew_window #(
  parameter int SKEW_CYC = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic open_o
);
  localparam int CW = (SKEW_CYC < 2) ? 1 : $clog2(SKEW_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = arm_i || (cnt_q != '0);
    cnt_d  = arm_i ? CW'(SKEW_CYC) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign open_o = (cnt_q != '0);
endmodule

// File: rtl/xmc_mode_fsm.sv
module xmc_mode_fsm
  import xmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rst_req_i,
  input  logic  en_s_i,
  input  logic  txd_s_i,
  input  logic  win_open_i,
  input  logic  lw_evt_i,
  input  logic  ign_evt_i,
  output logic  arm_o,
  output mode_e mode_o,
  output src_e  src_o
);
  mode_e mode_q, mode_d;
  src_e  src_q, src_d;
  logic  en_prev_q;
  logic  en_fall;

  assign en_fall = en_prev_q && !en_s_i;
  assign arm_o   = (mode_q == MODE_NORMAL) && en_fall && !rst_req_i;

  always_comb begin
    mode_d = mode_q;
    src_d  = src_q;
    if (rst_req_i) begin
      mode_d = MODE_FAILSAFE;
      src_d  = SRC_POWER;
    end else begin
      case (mode_q)
        MODE_FAILSAFE: if (en_s_i) mode_d = MODE_NORMAL;
        MODE_NORMAL:   if (en_fall) mode_d = txd_s_i ? MODE_SILENT : MODE_SLEEP;
        MODE_SILENT, MODE_SLEEP: begin
          if (lw_evt_i) begin
            mode_d = MODE_FAILSAFE;
            src_d  = SRC_LOCAL;
          end else if (ign_evt_i) begin
            mode_d = MODE_FAILSAFE;
            src_d  = SRC_IGN;
          end else if (mode_q == MODE_SILENT && win_open_i && !txd_s_i && !en_s_i) begin
            mode_d = MODE_SLEEP;
          end
        end
        default: mode_d = MODE_FAILSAFE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_FAILSAFE;
      src_q     <= SRC_POWER;
      en_prev_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      src_q     <= src_d;
      en_prev_q <= en_s_i;
    end
  end

  assign mode_o = mode_q;
  assign src_o  = src_q;
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
  import xmc_pkg::*;
#(
  parameter int LWAKE_DEB_CYC = 3500,
  parameter int IGN_DEB_CYC   = 8000,
  parameter int SKEW_CYC      = 160,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sbc_reset_i,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       wake_n_i,
  input  logic       ign_i,
  output logic [1:0] mode_o,
  output logic       reg_on_o,
  output logic       inh_on_o,
  output logic       xcvr_en_o,
  output logic       wdog_en_o,
  output logic [1:0] wake_src_o
);
  // pin order in the synchroniser: {ign, wake_n, txd, en}
  localparam logic [3:0] PIN_IDLE = 4'b0110;

  logic [3:0] pins_s;
  logic       lw_evt, ign_evt, arm, win_open;
  mode_e      mode;
  src_e       src;

  xmc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({ign_i, wake_n_i, txd_i, en_i}),
    .q_o(pins_s)
  );

  xmc_debounce #(.DEB_CYC(LWAKE_DEB_CYC)) u_deb_local (
    .clk(clk), .rst_n(rst_n), .act_i(!pins_s[2]), .rise_o(lw_evt)
  );

  xmc_debounce #(.DEB_CYC(IGN_DEB_CYC)) u_deb_ign (
    .clk(clk), .rst_n(rst_n), .act_i(pins_s[3]), .rise_o(ign_evt)
  );

  xmc_skew_window #(.SKEW_CYC(SKEW_CYC)) u_skew (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .open_o(win_open)
  );

  xmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .rst_req_i(sbc_reset_i),
    .en_s_i(pins_s[0]),
    .txd_s_i(pins_s[1]),
    .win_open_i(win_open),
    .lw_evt_i(lw_evt),
    .ign_evt_i(ign_evt),
    .arm_o(arm),
    .mode_o(mode),
    .src_o(src)
  );

  always_comb begin
    mode_o     = mode;
    reg_on_o   = (mode != MODE_SLEEP);
    inh_on_o   = (mode == MODE_FAILSAFE) || (mode == MODE_NORMAL);
    xcvr_en_o  = (mode == MODE_NORMAL);
    wdog_en_o  = (mode == MODE_FAILSAFE) || (mode == MODE_NORMAL);
    wake_src_o = (mode == MODE_FAILSAFE) ? src : SRC_NONE;
  end
endmodule

// File: rtl/xmc_checker.sv
module xmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sbc_reset_i,
  input logic [1:0] mode_o,
  input logic       reg_on_o,
  input logic       inh_on_o,
  input logic       xcvr_en_o,
  input logic       wdog_en_o,
  input logic [1:0] wake_src_o
);
  assert_failsafe_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> (reg_on_o && inh_on_o && !xcvr_en_o && wdog_en_o && wake_src_o != 2'b00));

  assert_normal_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01 && $past(mode_o) != 2'b01) |-> ($past(mode_o) == 2'b00));

  assert_silent_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |-> (reg_on_o && !inh_on_o && !xcvr_en_o && !wdog_en_o));

  assert_sleep_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> (!reg_on_o && !inh_on_o && !xcvr_en_o && !wdog_en_o));

  assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && $past(mode_o) != 2'b11) |->
      ($past(mode_o) == 2'b01 || $past(mode_o) == 2'b10));

  assert_silent_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && $past(mode_o) != 2'b10) |-> ($past(mode_o) == 2'b01));

  assert_reset_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sbc_reset_i |=> (mode_o == 2'b00 && wake_src_o == 2'b11));

  assert_src_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'b00) |-> (wake_src_o == 2'b00));
endmodule

bind xcvr_mode_ctrl xmc_checker u_xmc_checker (
  .clk(clk), .rst_n(rst_n), .sbc_reset_i(sbc_reset_i),
  .mode_o(mode_o), .reg_on_o(reg_on_o), .inh_on_o(inh_on_o),
  .xcvr_en_o(xcvr_en_o), .wdog_en_o(wdog_en_o), .wake_src_o(wake_src_o)
);

// File: tb/xcvr_mode_ctrl_bench.sv
module xcvr_mode_ctrl_bench;
  localparam int LW   = 35;
  localparam int IGN  = 80;
  localparam int SKEW = 16;

  localparam logic [1:0] M_FS = 2'b00, M_NO = 2'b01, M_SI = 2'b10, M_SL = 2'b11;
  localparam logic [3:0] O_FS = 4'b1101, O_NO = 4'b1111, O_SI = 4'b1000, O_SL = 4'b0000;

  // {en, txd, cycles[7:0], mode[1:0], outs{reg,inh,xcvr,wdog}}
  localparam logic [15:0] VEC [0:7] = '{
    {1'b0, 1'b1, 8'd4,  M_FS, O_FS},   // R1 idle in fail-safe
    {1'b1, 1'b1, 8'd5,  M_NO, O_NO},   // R2 enable -> normal
    {1'b1, 1'b0, 8'd5,  M_NO, O_NO},   // R2 txd toggles in normal
    {1'b1, 1'b1, 8'd5,  M_NO, O_NO},   // R2
    {1'b0, 1'b1, 8'd20, M_SI, O_SI},   // R3 enable falls, txd high
    {1'b1, 1'b1, 8'd5,  M_SI, O_SI},   // R9 enable rises in silent
    {1'b0, 1'b0, 8'd10, M_SI, O_SI},   // R9 late txd low, enable falls again
    {1'b0, 1'b1, 8'd5,  M_SI, O_SI}    // R9
  };

  logic clk, rst_n, sbc_reset_i, en_i, txd_i, wake_n_i, ign_i;
  logic [1:0] mode_o, wake_src_o;
  logic reg_on_o, inh_on_o, xcvr_en_o, wdog_en_o;
  int n_chk, n_err;
  bit done;

  xcvr_mode_ctrl #(.LWAKE_DEB_CYC(LW), .IGN_DEB_CYC(IGN), .SKEW_CYC(SKEW)) u_xcvr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sbc_reset_i(sbc_reset_i), .en_i(en_i), .txd_i(txd_i),
    .wake_n_i(wake_n_i), .ign_i(ign_i), .mode_o(mode_o), .reg_on_o(reg_on_o),
    .inh_on_o(inh_on_o), .xcvr_en_o(xcvr_en_o), .wdog_en_o(wdog_en_o), .wake_src_o(wake_src_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag, input logic [1:0] m, input logic [3:0] o,
                             input logic [1:0] s);
    check({tag, " mode"}, {6'd0, mode_o}, {6'd0, m});
    check({tag, " enables"}, {4'd0, reg_on_o, inh_on_o, xcvr_en_o, wdog_en_o}, {4'd0, o});
    check({tag, " source"}, {6'd0, wake_src_o}, {6'd0, s});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; sbc_reset_i = 1'b0; en_i = 1'b0; txd_i = 1'b1; wake_n_i = 1'b1; ign_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    check_state("R1 after reset", M_FS, O_FS, 2'b11);

    for (int i = 0; i < 8; i++) begin
      en_i  = VEC[i][15];
      txd_i = VEC[i][14];
      step(int'(VEC[i][13:6]));
      check_state($sformatf("R2/R3/R9 vector %0d", i), VEC[i][5:4], VEC[i][3:0],
                  (VEC[i][5:4] == M_FS) ? 2'b11 : 2'b00);
    end

    // R6 short local pulse is ignored, full pulse wakes
    wake_n_i = 1'b0; step(LW - 1); wake_n_i = 1'b1; step(LW + 5);
    check_state("R6 short local pulse", M_SI, O_SI, 2'b00);
    wake_n_i = 1'b0; step(LW); wake_n_i = 1'b1; step(4);
    check_state("R6 local wake", M_FS, O_FS, 2'b01);
    step(LW + 5);

    // R11 wake in normal mode has no effect
    en_i = 1'b1; step(5);
    wake_n_i = 1'b0; step(LW + 5);
    check_state("R11 wake in normal", M_NO, O_NO, 2'b00);
    wake_n_i = 1'b1; step(LW + 5);

    // R4 sleep entry with both edges together, R12 source masked
    en_i = 1'b0; txd_i = 1'b0; step(5);
    check_state("R4 R12 sleep entry", M_SL, O_SL, 2'b00);

    // R7 ignition short pulse, full pulse, steady high, falling edge
    ign_i = 1'b1; step(IGN - 1); ign_i = 1'b0; step(IGN + 5);
    check_state("R7 short ignition", M_SL, O_SL, 2'b00);
    ign_i = 1'b1; step(IGN + 4);
    check_state("R7 ignition wake", M_FS, O_FS, 2'b10);
    en_i = 1'b1; txd_i = 1'b1; step(5);
    en_i = 1'b0; txd_i = 1'b0; step(5 + 2 * IGN);
    check_state("R7 steady ignition high", M_SL, O_SL, 2'b00);
    ign_i = 1'b0; step(IGN + 5);
    check_state("R7 ignition falling", M_SL, O_SL, 2'b00);
    wake_n_i = 1'b0; step(LW + 4); wake_n_i = 1'b1;
    check_state("R6 wake from sleep", M_FS, O_FS, 2'b01);
    step(LW + 5);

    // R5 transmit falls on the last cycle of the window
    txd_i = 1'b1; en_i = 1'b1; step(5);
    en_i = 1'b0; step(SKEW); txd_i = 1'b0; step(5);
    check_state("R5 skew inside window", M_SL, O_SL, 2'b00);
    wake_n_i = 1'b0; step(LW + 4); wake_n_i = 1'b1; step(LW + 5);

    // R5 transmit falls one cycle after the window
    txd_i = 1'b1; en_i = 1'b1; step(5);
    en_i = 1'b0; step(SKEW + 1); txd_i = 1'b0; step(5);
    check_state("R5 skew past window", M_SI, O_SI, 2'b00);

    // R8 both wake filters complete on the same edge
    ign_i = 1'b1; step(IGN - LW);
    wake_n_i = 1'b0; step(LW + 4);
    check_state("R8 coincident wake", M_FS, O_FS, 2'b01);
    ign_i = 1'b0; wake_n_i = 1'b1; step(IGN + 5);

    // R10 reset request overrides enable, also from sleep
    txd_i = 1'b1; en_i = 1'b1; step(5);
    check_state("R2 normal again", M_NO, O_NO, 2'b00);
    sbc_reset_i = 1'b1; step(2);
    check_state("R10 reset request in normal", M_FS, O_FS, 2'b11);
    sbc_reset_i = 1'b0; step(2);
    check_state("R10 release returns to normal", M_NO, O_NO, 2'b00);
    en_i = 1'b0; txd_i = 1'b0; step(5);
    check_state("R4 sleep before reset", M_SL, O_SL, 2'b00);
    sbc_reset_i = 1'b1; step(1);
    check_state("R10 reset request in sleep", M_FS, O_FS, 2'b11);
    sbc_reset_i = 1'b0; step(2);
    check_state("R10 stays fail-safe", M_FS, O_FS, 2'b11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule